// File: doc/BRIEF.md
# Slave Message Register Decoder

This block sits on the slave side of a two-party, bit-handshaked serial link, behind the receiver that assembles incoming 9-bit messages. Each message is a byte plus a leading flag. A clear flag marks the byte as a payload, which is latched into a held data register. A set flag marks the byte as an instruction, which is issued to the instruction interpreter as a one-cycle strobe. The strobe carries the opcode and the value currently held in the data register.

The slave has no right to speak first. A reply byte is queued toward the bit transmitter only when an instruction asks for one. The single example instruction is the read-back opcode. It queues the held data register, tagged as a payload with the flag clear. The queued reply stays requested until the transmitter accepts it.

Top module: `slave_msg_decoder`

## Requirements
- R1: After reset the held data register reads 0, the instruction strobe is low and no reply is requested.
- R2: A message with flag 0 loads its byte into the held data register, which is visible on `data_q` one cycle after the message is presented.
- R3: A later payload message overwrites the held register. No error or other indication is raised.
- R4: A payload message raises no instruction strobe and does not request a reply.
- R5: A message with flag 1 produces `cmd_strobe` high for exactly one cycle, one cycle after the message, with `cmd_opcode` equal to the message byte.
- R6: `cmd_operand` carries the held register value in force when the instruction arrived. An instruction never alters the held register.
- R7: Opcode 0x01 (read-back) raises `tx_req` one cycle later, with `tx_byte` equal to the held register and `tx_flag` equal to 0.
- R8: `tx_req` stays high until a cycle in which `tx_ack` is high, and is low from the next cycle on.
- R9: `tx_req` never rises except after a read-back instruction. All other opcodes leave it low.
- R10: A read-back arriving while a reply is still pending reloads `tx_byte` with the current held register and keeps `tx_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A received message is present this cycle |
| msg_is_cmd | input | 1 | Flag of the message: 1 = instruction, 0 = payload |
| msg_byte | input | 8 | Byte of the message |
| data_q | output | 8 | Held data register |
| cmd_strobe | output | 1 | One-cycle instruction issue pulse |
| cmd_opcode | output | 8 | Opcode of the issued instruction |
| cmd_operand | output | 8 | Held data value passed with the instruction |
| tx_req | output | 1 | Reply byte waiting for the transmitter |
| tx_flag | output | 1 | Flag to send with the reply (always payload) |
| tx_byte | output | 8 | Reply byte |
| tx_ack | input | 1 | Transmitter takes the pending reply |

## Verification
Every byte value is sent as a payload. Each payload is followed by an instruction whose opcode is a fixed bijective scramble of that byte, so every opcode is issued once, including read-back, and always against a known held value. This separates payload routing from instruction routing, and a stale operand from a fresh one. It also tells the single read-back opcode apart from the 255 opcodes that must stay silent. Idle cycles after each instruction show whether the strobe is a single pulse and whether a pending reply holds until acknowledged. A back-to-back read-back sequence checks that the reply is reloaded.

// File: rtl/slave_msg_pkg.sv
package slave_msg_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  flag;
    byte_t value;
  } reply_t;

  function automatic logic is_payload(input logic valid, input logic is_cmd);
    return valid && !is_cmd;
  endfunction

  function automatic logic is_instr(input logic valid, input logic is_cmd);
    return valid && is_cmd;
  endfunction

  function automatic logic wants_reply(input logic fire, input byte_t op, input byte_t rb_op);
    return fire && (op == rb_op);
  endfunction
endpackage

// File: rtl/sd_data_hold.sv
module sd_data_hold
  import slave_msg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t din,
  output byte_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  assert_hold_only_on_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> $past(load));
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import slave_msg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  byte_t opcode_in,
  input  byte_t held,
  output logic  strobe,
  output byte_t opcode,
  output byte_t operand
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe  <= 1'b0;
      opcode  <= '0;
      operand <= '0;
    end else begin
      strobe <= fire;
      if (fire) begin
        opcode  <= opcode_in;
        operand <= held;
      end
    end
  end

  assert_strobe_from_instr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(fire));
  assert_operand_is_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire) |-> (operand == $past(held)));
endmodule

// File: rtl/sd_reply_slot.sv
module sd_reply_slot
  import slave_msg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  byte_t  value,
  input  logic   ack,
  output logic   pending,
  output reply_t slot
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      slot    <= '0;
    end else if (load) begin
      pending    <= 1'b1;
      slot.flag  <= 1'b0;
      slot.value <= value;
    end else if (ack) begin
      pending <= 1'b0;
    end
  end

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);
  assert_reply_is_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (pending && slot.value == $past(value)));
endmodule

// File: rtl/slave_msg_decoder.sv
module slave_msg_decoder
  import slave_msg_pkg::*;
#(
  parameter logic [7:0] OP_READBACK = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       msg_valid,
  input  logic       msg_is_cmd,
  input  logic [7:0] msg_byte,
  output logic [7:0] data_q,
  output logic       cmd_strobe,
  output logic [7:0] cmd_opcode,
  output logic [7:0] cmd_operand,
  output logic       tx_req,
  output logic       tx_flag,
  output logic [7:0] tx_byte,
  input  logic       tx_ack
);
  logic   data_load;
  logic   cmd_fire;
  logic   reply_load;
  reply_t reply;

  assign data_load  = is_payload(msg_valid, msg_is_cmd);
  assign cmd_fire   = is_instr(msg_valid, msg_is_cmd);
  assign reply_load = wants_reply(cmd_fire, msg_byte, OP_READBACK);

  sd_data_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load(data_load), .din(msg_byte), .q(data_q)
  );

  sd_cmd_issue u_issue (
    .clk(clk), .rst_n(rst_n), .fire(cmd_fire), .opcode_in(msg_byte),
    .held(data_q), .strobe(cmd_strobe), .opcode(cmd_opcode), .operand(cmd_operand)
  );

  sd_reply_slot u_reply (
    .clk(clk), .rst_n(rst_n), .load(reply_load), .value(data_q),
    .ack(tx_ack), .pending(tx_req), .slot(reply)
  );

  assign tx_flag = reply.flag;
  assign tx_byte = reply.value;

  assert_payload_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_is_cmd) |=> !cmd_strobe);
  assert_tx_only_on_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> $past(msg_valid && msg_is_cmd && msg_byte == OP_READBACK));
  assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_ack && !reply_load) |=> !tx_req);
endmodule

// File: tb/slave_msg_decoder_bench.sv
module slave_msg_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       msg_valid, msg_is_cmd, tx_ack;
  logic [7:0] msg_byte;
  logic [7:0] data_q, cmd_opcode, cmd_operand, tx_byte;
  logic       cmd_strobe, tx_req, tx_flag;
  int         n_vec = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  slave_msg_decoder u_slave_msg_decoder (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_is_cmd(msg_is_cmd),
    .msg_byte(msg_byte), .data_q(data_q), .cmd_strobe(cmd_strobe),
    .cmd_opcode(cmd_opcode), .cmd_operand(cmd_operand), .tx_req(tx_req),
    .tx_flag(tx_flag), .tx_byte(tx_byte), .tx_ack(tx_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present one message for one edge, then sample at the following negedge
  task automatic send(input bit cmd, input logic [7:0] b);
    msg_valid = 1'b1; msg_is_cmd = cmd; msg_byte = b;
    @(negedge clk);
    msg_valid = 1'b0; msg_is_cmd = 1'b0; msg_byte = 8'h00;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic ack_reply();
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
  endtask

  function automatic logic [7:0] scramble(input logic [7:0] v);
    return (v * 8'd37 + 8'd11) ^ 8'h5A;
  endfunction

  initial begin
    #1_600_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; msg_valid = 1'b0; msg_is_cmd = 1'b0; msg_byte = 8'h00; tx_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(data_q == 8'h00, "R1 data_q", data_q, 0);
    chk(cmd_strobe == 1'b0, "R1 cmd_strobe", cmd_strobe, 0);
    chk(tx_req == 1'b0, "R1 tx_req", tx_req, 0);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] op;
      op = scramble(8'(v));
      send(1'b0, 8'(v));
      chk(data_q == 8'(v), "R2/R3 data_q", data_q, v);
      chk(cmd_strobe == 1'b0, "R4 cmd_strobe", cmd_strobe, 0);
      chk(tx_req == 1'b0, "R4 tx_req", tx_req, 0);
      send(1'b1, op);
      chk(cmd_strobe == 1'b1, "R5 cmd_strobe", cmd_strobe, 1);
      chk(cmd_opcode == op, "R5 cmd_opcode", cmd_opcode, op);
      chk(cmd_operand == 8'(v), "R6 cmd_operand", cmd_operand, v);
      chk(data_q == 8'(v), "R6 data_q kept", data_q, v);
      chk(tx_req == (op == 8'h01), "R7/R9 tx_req", tx_req, int'(op == 8'h01));
      idle();
      chk(cmd_strobe == 1'b0, "R5 single pulse", cmd_strobe, 0);
      if (op == 8'h01) begin
        chk(tx_byte == 8'(v), "R7 tx_byte", tx_byte, v);
        chk(tx_flag == 1'b0, "R7 tx_flag", tx_flag, 0);
        repeat (3) idle();
        chk(tx_req == 1'b1, "R8 hold", tx_req, 1);
        ack_reply();
        chk(tx_req == 1'b0, "R8 drop", tx_req, 0);
      end else begin
        chk(tx_req == 1'b0, "R9 tx_req", tx_req, 0);
      end
    end

    // R10: second read-back while the first is pending
    send(1'b0, 8'h33);
    send(1'b1, 8'h01);
    chk(tx_byte == 8'h33, "R10 first", tx_byte, 8'h33);
    send(1'b0, 8'h44);
    chk(tx_byte == 8'h33, "R10 unchanged by payload", tx_byte, 8'h33);
    send(1'b1, 8'h01);
    chk(tx_req == 1'b1, "R10 tx_req", tx_req, 1);
    chk(tx_byte == 8'h44, "R10 reloaded", tx_byte, 8'h44);
    ack_reply();
    chk(tx_req == 1'b0, "R8 drop after reload", tx_req, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule